// File: doc/BRIEF.md
# Dual-Mode Serial Character Transmitter

This block takes one byte at a time from a load port with a valid/ready handshake and shifts it out, least significant bit first, on one serial data line. There are two modes. In asynchronous mode each character is framed by a low start bit and a high stop bit. Each bit lasts a fixed number of baud-tick enables. The character length can be seven or eight bits, and an even or odd parity bit can be added. In clock-synchronous mode the block also drives a shift clock output. Every character is then exactly eight data bits, with no framing and no parity.

The mode, length and parity settings are sampled when a byte is accepted and stay fixed for that character. A separate baud generator supplies the tick enable, which paces all bit timing. The load port shows ready only while no character is in flight.

Top module: `sertx_dual`

## Requirements
- R1: After reset, `sdo` is 1, `sclk` is 1 and `ld_ready` is 1.
- R2: In asynchronous mode (`cfg_sync`=0), a character is sent as one low start bit, then the data bits LSB first, then one high stop bit. Each bit lasts `OVS` (default 16) tick enables, and `sclk` stays 1 throughout.
- R3: With `cfg_len7`=1 in asynchronous mode, only bits 6..0 are sent. Bit 7 of the byte is not sent, and the next bit after bit 6 is the parity bit or the stop bit.
- R4: With `cfg_par_en`=1 in asynchronous mode, one parity bit is inserted between the last data bit and the stop bit.
- R5: The parity bit makes the number of ones across the sent data bits and the parity bit even when `cfg_par_odd`=0, and odd when `cfg_par_odd`=1.
- R6: With `cfg_par_en`=0, the frame is the same whatever the value of `cfg_par_odd`.
- R7: In clock-synchronous mode (`cfg_sync`=1), exactly eight data bits are sent LSB first, with no start bit, stop bit or parity bit, whatever the values of `cfg_len7`, `cfg_par_en` and `cfg_par_odd`.
- R8: In clock-synchronous mode, `sclk` falls and `sdo` takes the next bit at the start of each bit. `sclk` rises after `SYNC_HALF` (default 4) tick enables and stays high for `SYNC_HALF` more. After the eighth bit, `sclk` stays high and `sdo` returns to 1.
- R9: `ld_ready` goes low in the cycle after a byte is accepted. It stays low until the last bit period ends, and returns high at that edge. A `ld_valid` presented while `ld_ready` is low is ignored and does not alter the frame in flight.
- R10: Bit timing advances only on cycles with `tick_en`=1. While a character is in flight and `tick_en` is 0, `sdo`, `sclk` and `ld_ready` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A byte is offered on `ld_data` |
| ld_ready | output | 1 | Transmitter is idle and will accept a byte |
| ld_data | input | 8 | Byte to transmit |
| cfg_sync | input | 1 | 1 = clock-synchronous mode, 0 = asynchronous |
| cfg_len7 | input | 1 | Asynchronous only: 1 = 7 data bits, 0 = 8 |
| cfg_par_en | input | 1 | Asynchronous only: 1 = add a parity bit |
| cfg_par_odd | input | 1 | Parity polarity: 1 = odd, 0 = even |
| tick_en | input | 1 | Baud-tick enable that paces the bit timing |
| sdo | output | 1 | Serial data output, idles high |
| sclk | output | 1 | Shift clock output, idles high, toggles only in synchronous mode |

## Verification
The assertions check five relations on every cycle: both lines sit high whenever the port is ready, the shift clock stays high in an asynchronous frame, and a data change in synchronous mode happens only together with a falling shift clock. They also check that each accepted byte starts with the right first line state, and that nothing moves in a cycle without a tick. The exact frame contents can only be shown by the bench's scenarios: bit order, the dropped eighth bit, parity placement and polarity, the eight-bit override in synchronous mode, bit lengths counted in ticks, the moment ready returns, and the rejection of a load while busy.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 11;
    localparam int NB_W    = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic sync;
        logic len7;
        logic par_en;
        logic par_odd;
    } cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [NB_W-1:0]    nbits;
        logic               sync;
    } frame_t;

    // Parity over the data bits that are actually sent
    function automatic logic par_of(logic [DATA_W-1:0] d, logic len7, logic odd);
        logic p;
        p = odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (!(len7 && i == DATA_W - 1)) p = p ^ d[i];
        end
        return p;
    endfunction

    // Lay out the line sequence, element 0 first on the wire, unused tail high
    function automatic frame_t build_frame(logic [DATA_W-1:0] d, cfg_t c);
        frame_t f;
        int     idx;
        f.bits = '1;
        f.sync = c.sync;
        if (c.sync) begin
            f.bits[DATA_W-1:0] = d;
            f.nbits = NB_W'(DATA_W);
        end else begin
            f.bits[0] = 1'b0;
            idx = 1;
            for (int i = 0; i < DATA_W; i++) begin
                if (!(c.len7 && i == DATA_W - 1)) begin
                    f.bits[idx] = d[i];
                    idx++;
                end
            end
            if (c.par_en) begin
                f.bits[idx] = par_of(d, c.len7, c.par_odd);
                idx++;
            end
            f.bits[idx] = 1'b1;
            idx++;
            f.nbits = NB_W'(idx);
        end
        return f;
    endfunction

endpackage

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  cfg_t              cfg,
    output frame_t            frame
);
    always_comb frame = build_frame(data, cfg);
endmodule

// File: rtl/sertx_timer.sv
module sertx_timer #(
    parameter int OVS       = 16,
    parameter int SYNC_HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    input  logic sync,
    input  logic tick,
    output logic mid,
    output logic bit_end
);
    localparam int SYNC_BIT = 2 * SYNC_HALF;
    localparam int MAXLIM   = (OVS > SYNC_BIT) ? OVS : SYNC_BIT;
    localparam int CW       = $clog2(MAXLIM + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic          step;

    assign last    = sync ? CW'(SYNC_BIT - 1) : CW'(OVS - 1);
    assign step    = run && tick;
    assign bit_end = step && (cnt == last);
    assign mid     = step && sync && (cnt == CW'(SYNC_HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt <= '0;
        end else if (step) begin
            if (cnt == last) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame,
    input  logic   mid,
    input  logic   bit_end,
    output logic   busy,
    output logic   mode_sync,
    output logic   sdo,
    output logic   sclk
);
    logic [FRAME_W-1:0] sh;
    logic [NB_W-1:0]    rem;

    assign sdo = sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '1;
            rem       <= '0;
            busy      <= 1'b0;
            mode_sync <= 1'b0;
            sclk      <= 1'b1;
        end else if (load) begin
            sh        <= frame.bits;
            rem       <= frame.nbits;
            busy      <= 1'b1;
            mode_sync <= frame.sync;
            sclk      <= !frame.sync;
        end else if (busy) begin
            if (mid && mode_sync) sclk <= 1'b1;
            if (bit_end) begin
                if (rem == NB_W'(1)) begin
                    sh   <= '1;
                    busy <= 1'b0;
                    sclk <= 1'b1;
                end else begin
                    sh  <= {1'b1, sh[FRAME_W-1:1]};
                    rem <= rem - 1'b1;
                    if (mode_sync) sclk <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sertx_dual.sv
module sertx_dual
    import sertx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int SYNC_HALF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              cfg_sync,
    input  logic              cfg_len7,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              tick_en,
    output logic              sdo,
    output logic              sclk
);
    cfg_t   cfg;
    frame_t frame;
    logic   busy, mode_sync, load, mid, bit_end;

    assign cfg      = '{sync: cfg_sync, len7: cfg_len7, par_en: cfg_par_en, par_odd: cfg_par_odd};
    assign ld_ready = !busy;
    assign load     = ld_valid && ld_ready;

    sertx_framer u_framer (
        .data (ld_data),
        .cfg  (cfg),
        .frame(frame)
    );

    sertx_timer #(.OVS(OVS), .SYNC_HALF(SYNC_HALF)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (load),
        .run    (busy),
        .sync   (mode_sync),
        .tick   (tick_en),
        .mid    (mid),
        .bit_end(bit_end)
    );

    sertx_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .frame    (frame),
        .mid      (mid),
        .bit_end  (bit_end),
        .busy     (busy),
        .mode_sync(mode_sync),
        .sdo      (sdo),
        .sclk     (sclk)
    );
endmodule

// File: rtl/sertx_dual_chk.sv
module sertx_dual_chk (
    input logic clk,
    input logic rst,
    input logic ld_valid,
    input logic ld_ready,
    input logic ld_bit0,
    input logic cfg_sync,
    input logic tick_en,
    input logic sdo,
    input logic sclk
);
    logic m_sync;
    logic hs;

    assign hs = ld_valid && ld_ready;

    always_ff @(posedge clk) begin
        if (rst)     m_sync <= 1'b0;
        else if (hs) m_sync <= cfg_sync;
    end

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
        ld_ready |-> (sdo && sclk));

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (hs && !cfg_sync) |=> (!sdo && !ld_ready));

    p_async_clk_high_r2: assert property (@(posedge clk) disable iff (rst)
        (!ld_ready && !m_sync) |-> sclk);

    p_sync_first_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (hs && cfg_sync) |=> (!sclk && (sdo == $past(ld_bit0))));

    p_sync_change_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (!ld_ready && $past(!ld_ready) && m_sync && !$stable(sdo)) |-> $fell(sclk));

    p_hold_without_tick_r10: assert property (@(posedge clk) disable iff (rst)
        (!ld_ready && !tick_en) |=> ($stable(sdo) && $stable(sclk) && !ld_ready));
endmodule

bind sertx_dual sertx_dual_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ld_valid(ld_valid),
    .ld_ready(ld_ready),
    .ld_bit0 (ld_data[0]),
    .cfg_sync(cfg_sync),
    .tick_en (tick_en),
    .sdo     (sdo),
    .sclk    (sclk)
);

// File: tb/sertx_dual_test.sv
module sertx_dual_test;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;
    localparam int SH         = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_valid = 1'b0;
    logic       ld_ready;
    logic [7:0] ld_data = 8'h00;
    logic       cfg_sync = 1'b0, cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       tick_en = 1'b1;
    logic       sdo, sclk;

    int n_checks = 0;
    int n_fail   = 0;
    int pos      = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sertx_dual #(.OVS(OVS), .SYNC_HALF(SH)) uut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
        .cfg_sync(cfg_sync), .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .tick_en(tick_en), .sdo(sdo), .sclk(sclk)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic adv_to(input int p);
        while (pos < p) begin
            @(posedge clk);
            @(negedge clk);
            pos++;
        end
    endtask

    // Expected async line sequence from the requirements
    task automatic exp_async(input logic [7:0] d, input bit len7, input bit pe, input bit odd,
                             output logic [15:0] seq, output int n);
        int ones;
        seq = '1;
        ones = 0;
        seq[0] = 1'b0;
        n = 1;
        for (int i = 0; i < (len7 ? 7 : 8); i++) begin
            seq[n] = d[i];
            ones += d[i];
            n++;
        end
        if (pe) begin
            seq[n] = odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
            n++;
        end
        seq[n] = 1'b1;
        n++;
    endtask

    // Accept one byte and check the whole character; stall holds tick low first
    task automatic run_char(input string req, input logic [7:0] d, input bit sync, input bit len7,
                            input bit pe, input bit odd, input int stall, input bit poke);
        logic [15:0] seq;
        int          n, blen, total;
        @(negedge clk);
        check(ld_ready == 1'b1, req, "ready before load", ld_ready, 1);
        ld_data = d; cfg_sync = sync; cfg_len7 = len7; cfg_par_en = pe; cfg_par_odd = odd;
        ld_valid = 1'b1;
        if (stall > 0) tick_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        pos = 0;
        check(ld_ready == 1'b0, req, "ready after load", ld_ready, 0);
        if (stall > 0) begin
            for (int s = 1; s <= stall; s += 13) begin
                adv_to(s);
                check(sdo == (sync ? d[0] : 1'b0) && sclk == !sync && !ld_ready,
                      req, "held without tick", {sdo, sclk}, {sync ? d[0] : 1'b0, !sync});
            end
            adv_to(stall);
            tick_en = 1'b1;
        end
        if (sync) begin
            n = 8; blen = 2 * SH;
            for (int i = 0; i < 8; i++) seq[i] = d[i];
        end else begin
            exp_async(d, len7, pe, odd, seq, n);
            blen = OVS;
        end
        total = n * blen;
        for (int k = 0; k < n; k++) begin
            if (poke && k == 2) begin
                adv_to(stall + k * blen + 1);
                ld_data = ~d; ld_valid = 1'b1;
            end
            if (poke && k == 3) begin
                adv_to(stall + k * blen);
                ld_valid = 1'b0;
            end
            if (sync) begin
                adv_to(stall + k * blen + 2);
                check(sdo == seq[k] && sclk == 1'b0, req, $sformatf("sync bit %0d low half", k),
                      {sdo, sclk}, {seq[k], 1'b0});
                adv_to(stall + k * blen + SH + 2);
                check(sdo == seq[k] && sclk == 1'b1, req, $sformatf("sync bit %0d high half", k),
                      {sdo, sclk}, {seq[k], 1'b1});
            end else begin
                adv_to(stall + k * blen + 1);
                check(sdo == seq[k], req, $sformatf("async bit %0d early", k), sdo, seq[k]);
                adv_to(stall + k * blen + blen - 1);
                check(sdo == seq[k] && sclk == 1'b1, req, $sformatf("async bit %0d late", k),
                      {sdo, sclk}, {seq[k], 1'b1});
            end
        end
        adv_to(stall + total - 1);
        check(ld_ready == 1'b0, "R9", "ready low in last bit", ld_ready, 0);
        adv_to(stall + total);
        check(ld_ready == 1'b1 && sdo && sclk, "R9", "idle after last bit",
              {ld_ready, sdo, sclk}, 7);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check(ld_ready == 1'b1 && sdo == 1'b1 && sclk == 1'b1, "R1", "reset state",
              {ld_ready, sdo, sclk}, 7);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        run_char("R2", 8'hA5, 0, 0, 0, 0, 0, 0);
        run_char("R2", 8'h01, 0, 0, 0, 0, 0, 0);
        run_char("R4", 8'hA5, 0, 0, 1, 0, 0, 0);   // R5 even, four ones -> parity 0
        run_char("R5", 8'hA5, 0, 0, 1, 1, 0, 0);
        run_char("R5", 8'h00, 0, 0, 1, 1, 0, 0);
        run_char("R5", 8'h07, 0, 0, 1, 0, 0, 0);
        run_char("R3", 8'hC3, 0, 1, 0, 0, 0, 0);
        run_char("R3", 8'h80, 0, 1, 1, 0, 0, 0);   // bit 7 not counted in parity
        run_char("R6", 8'h5A, 0, 0, 0, 1, 0, 0);
        run_char("R7", 8'hB4, 1, 1, 1, 1, 0, 0);
        run_char("R8", 8'h81, 1, 0, 0, 0, 0, 0);
        run_char("R10", 8'h3C, 0, 0, 1, 0, 40, 0);
        run_char("R10", 8'h69, 1, 0, 0, 0, 30, 0);
        run_char("R9", 8'h96, 0, 0, 0, 0, 0, 1);
        run_char("R9", 8'h2D, 1, 0, 0, 0, 0, 1);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule